// File: doc/BRIEF.md
# Translation Table Update Command Engine

The engine owns a small set of paged address-translation tables and executes software commands against them, one at a time. A command names a table by a 64-bit identifier and gives an I/O bus address. The engine aligns that address down to the table's page size, subtracts the table's bus offset and shifts by the page size to find an entry. It then writes or reads that entry and returns a status. Four operations exist: write one entry, read one entry, fill a run of consecutive entries with one value, and write a run of consecutive entries from values delivered one by one on a stream port. Fetching those values from system memory is left to the stream source.

Every entry that is written produces a one-cycle invalidate notification. It carries the page-aligned I/O address relative to the table base, the page-aligned target address, the in-page address mask and the decoded access permission. Downstream translation caches use it to drop stale mappings. Run commands step one page per entry and stop at the first entry that falls outside the table. Entries written before that point stay written.

Control is a five-state machine. IDLE accepts a command (IDLE→DECODE). DECODE resolves the table and runs the command-level checks: a failing check goes to DONE, a stream-fed run goes to FETCH, and anything else goes to STEP. FETCH waits for one stream value (FETCH→STEP). STEP handles one entry. It goes to DONE on an out-of-range entry, after a read, or after the last entry of a run. Otherwise it goes to FETCH for a stream-fed run or stays in STEP for a fill. DONE presents the response for one cycle and returns to IDLE.

Top module: `tce_cmd_engine`

## Requirements
- R1: An identifier with any of bits 63:32 set is rejected with status 4, even if its low half matches a table, and nothing is written or notified.
- R2: An identifier whose low 32 bits match no configured table tag is rejected with status 4.
- R3: The entry index is ((address with its low page_shift bits cleared) − bus_offset) >> page_shift. An index at or above the table's entry count returns status 4 and writes nothing. This includes an address below the offset. Status is 0 on success and 4 on any parameter error.
- R4: A single write (op 0) stores the value and emits one notification. The notification carries iova = relative address with the low page bits cleared, target = value with the low page bits cleared, mask = 2^page_shift − 1, and perm = value[1:0] (0 none, 1 read-only, 2 write-only, 3 read-write).
- R5: A read (op 1) returns the stored value with status 0. On any error it returns status 4 with value 0. A read emits no notification.
- R6: A fill (op 2) with a count greater than the table's entry count, or with a count of 0, returns status 4 and writes nothing.
- R7: A fill writes its value to consecutive entries, advancing the address by one page per entry. At the first out-of-range entry it stops with status 4, keeping the earlier writes.
- R8: A list write (op 3) with a count above 512 or 0, or with a list address whose bits 11:0 are not zero, returns status 4, takes nothing from the stream and writes nothing.
- R9: A list write takes exactly one stream value per attempted entry and writes it to consecutive pages, stopping at the first out-of-range entry. It reports as its last index the number of successful entries minus one, or 0 when none succeeded.
- R10: A command is accepted only when cmd_ready is high. busy is high from acceptance until the single-cycle response has been presented, and the engine is ready again on the next cycle.
- R11: Reset clears every table entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tag | input | NUM_TABLES×32 | Identifier tag of each table |
| cfg_offset | input | NUM_TABLES×ADDR_W | Bus offset of each table |
| cfg_shift | input | NUM_TABLES×6 | Page size exponent of each table |
| cfg_count | input | NUM_TABLES×32 | Entry count of each table (clamped to DEPTH) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken this cycle |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list write |
| cmd_table | input | 64 | Table identifier |
| cmd_addr | input | ADDR_W | I/O bus address of the first entry |
| cmd_arg | input | ADDR_W | Entry value (write, fill) or list address (list write) |
| cmd_count | input | 32 | Entry count for fill and list write |
| lst_valid | input | 1 | Stream value offered |
| lst_ready | output | 1 | Stream value taken this cycle |
| lst_data | input | ADDR_W | Stream value |
| busy | output | 1 | Command in flight |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_status | output | 8 | 0 success, 4 parameter error |
| rsp_value | output | ADDR_W | Entry read by op 1, else 0 |
| rsp_last_idx | output | 32 | Last successful list entry position |
| inv_valid | output | 1 | Invalidate notification |
| inv_iova | output | ADDR_W | Page-aligned relative I/O address |
| inv_target | output | ADDR_W | Page-aligned target address |
| inv_mask | output | ADDR_W | In-page address mask |
| inv_perm | output | 2 | Decoded permission |

## Verification
A wrong stepping address or index in the engine shows up as a notification with the wrong iova on the very cycle after the faulty STEP, and as a wrong value on the next read of either entry involved. A wrong early stop or late stop changes the number of notifications, the stream values taken and the reported last index. All of these are seen by the end of the same command. A state machine that skips or repeats FETCH shows up at once as a stream handshake outside the window in which values are owed, or as a response that never comes. A table select that ignores the identifier's upper half, or that uses the wrong table's offset or shift, gives the wrong status or iova on the first command that exercises it.

// File: rtl/tce_pkg.sv
`timescale 1ns/1ps
package tce_pkg;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LIST = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_FETCH,
        ST_STEP,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    localparam int STS_W = 8;
    localparam logic [STS_W-1:0] STS_OK    = 8'd0;
    localparam logic [STS_W-1:0] STS_PARAM = 8'd4;

    function automatic perm_e decode_perm(input logic [1:0] bits);
        perm_e p;
        unique case (bits)
            2'd0:    p = PERM_NONE;
            2'd1:    p = PERM_RD;
            2'd2:    p = PERM_WR;
            default: p = PERM_RW;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/tce_table_select.sv
`timescale 1ns/1ps
module tce_table_select #(
    parameter int NUM_TABLES = 2,
    parameter int DEPTH      = 16,
    parameter int ID_W       = 64,
    parameter int TAG_W      = 32,
    parameter int ADDR_W     = 64,
    parameter int SHIFT_W    = 6,
    parameter int CNT_W      = 32,
    localparam int SEL_W     = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
    input  logic [ID_W-1:0]               id,
    input  logic [NUM_TABLES*TAG_W-1:0]   cfg_tag,
    input  logic [NUM_TABLES*ADDR_W-1:0]  cfg_offset,
    input  logic [NUM_TABLES*SHIFT_W-1:0] cfg_shift,
    input  logic [NUM_TABLES*CNT_W-1:0]   cfg_count,
    output logic                          hit,
    output logic [SEL_W-1:0]              sel,
    output logic [ADDR_W-1:0]             offset,
    output logic [SHIFT_W-1:0]            shift,
    output logic [CNT_W-1:0]              count
);
    logic             upper_clear;
    logic [CNT_W-1:0] raw_count;

    assign upper_clear = (id[ID_W-1:TAG_W] == '0);

    // Lowest-numbered matching table wins.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int t = NUM_TABLES - 1; t >= 0; t--) begin
            if (upper_clear && (id[TAG_W-1:0] == cfg_tag[t*TAG_W +: TAG_W])) begin
                hit = 1'b1;
                sel = SEL_W'(t);
            end
        end
    end

    assign offset    = cfg_offset[int'(sel)*ADDR_W +: ADDR_W];
    assign shift     = cfg_shift[int'(sel)*SHIFT_W +: SHIFT_W];
    assign raw_count = cfg_count[int'(sel)*CNT_W +: CNT_W];
    assign count     = (raw_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : raw_count;

endmodule

// File: rtl/tce_index_calc.sv
`timescale 1ns/1ps
module tce_index_calc #(
    parameter int ADDR_W  = 64,
    parameter int SHIFT_W = 6,
    parameter int CNT_W   = 32,
    parameter int IDX_W   = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  offset,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CNT_W-1:0]   count,
    output logic [ADDR_W-1:0]  low_mask,
    output logic [ADDR_W-1:0]  page_size,
    output logic [ADDR_W-1:0]  aligned,
    output logic [ADDR_W-1:0]  rel_page,
    output logic [IDX_W-1:0]   idx,
    output logic               in_range
);
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] full_idx;

    assign page_size = ADDR_W'(1) << shift;
    assign low_mask  = page_size - ADDR_W'(1);
    assign aligned   = addr & ~low_mask;
    assign rel       = aligned - offset;
    assign rel_page  = rel & ~low_mask;
    assign full_idx  = rel >> shift;
    assign in_range  = full_idx < ADDR_W'(count);
    assign idx       = full_idx[IDX_W-1:0];

endmodule

// File: rtl/tce_entry_store.sv
`timescale 1ns/1ps
module tce_entry_store #(
    parameter int NUM_TABLES = 2,
    parameter int DEPTH      = 16,
    parameter int DATA_W     = 64,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int SEL_W     = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] rd_bank [NUM_TABLES];

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_bank
        logic [DATA_W-1:0] bank [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(t))) begin
                bank[wr_idx] <= wr_data;
            end
        end

        assign rd_bank[t] = bank[rd_idx];
    end

    assign rd_data = rd_bank[rd_sel];

endmodule

// File: rtl/tce_cmd_engine.sv
`timescale 1ns/1ps
module tce_cmd_engine
    import tce_pkg::*;
#(
    parameter int NUM_TABLES = 2,
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 64,
    parameter int ID_W       = 64,
    parameter int TAG_W      = 32,
    parameter int SHIFT_W    = 6,
    parameter int CNT_W      = 32,
    parameter int LIST_MAX   = 512,
    parameter int LIST_ALIGN = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_TABLES*TAG_W-1:0]   cfg_tag,
    input  logic [NUM_TABLES*ADDR_W-1:0]  cfg_offset,
    input  logic [NUM_TABLES*SHIFT_W-1:0] cfg_shift,
    input  logic [NUM_TABLES*CNT_W-1:0]   cfg_count,
    input  logic                          cmd_valid,
    output logic                          cmd_ready,
    input  logic [1:0]                    cmd_op,
    input  logic [ID_W-1:0]               cmd_table,
    input  logic [ADDR_W-1:0]             cmd_addr,
    input  logic [ADDR_W-1:0]             cmd_arg,
    input  logic [CNT_W-1:0]              cmd_count,
    input  logic                          lst_valid,
    output logic                          lst_ready,
    input  logic [ADDR_W-1:0]             lst_data,
    output logic                          busy,
    output logic                          rsp_valid,
    output logic [STS_W-1:0]              rsp_status,
    output logic [ADDR_W-1:0]             rsp_value,
    output logic [CNT_W-1:0]              rsp_last_idx,
    output logic                          inv_valid,
    output logic [ADDR_W-1:0]             inv_iova,
    output logic [ADDR_W-1:0]             inv_target,
    output logic [ADDR_W-1:0]             inv_mask,
    output logic [1:0]                    inv_perm
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int SEL_W = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1;

    state_e            state, nstate;
    op_e               op_q;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] arg_q;
    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] cur_val;
    logic [CNT_W-1:0]  done_cnt;
    logic [STS_W-1:0]  sts_q;
    logic [ADDR_W-1:0] val_q;

    // table resolution
    logic               t_hit;
    logic [SEL_W-1:0]   t_sel;
    logic [ADDR_W-1:0]  t_offset;
    logic [SHIFT_W-1:0] t_shift;
    logic [CNT_W-1:0]   t_count;

    // per-entry address arithmetic
    logic [ADDR_W-1:0] low_mask, page_size, aligned, rel_page;
    logic [IDX_W-1:0]  entry_idx;
    logic              in_range;

    logic [ADDR_W-1:0] rd_data;
    logic              wr_en;
    logic              list_bad, fill_bad, pre_err;
    logic [CNT_W-1:0]  total;
    logic              last_entry;

    tce_table_select #(
        .NUM_TABLES (NUM_TABLES),
        .DEPTH      (DEPTH),
        .ID_W       (ID_W),
        .TAG_W      (TAG_W),
        .ADDR_W     (ADDR_W),
        .SHIFT_W    (SHIFT_W),
        .CNT_W      (CNT_W)
    ) u_select (
        .id         (id_q),
        .cfg_tag    (cfg_tag),
        .cfg_offset (cfg_offset),
        .cfg_shift  (cfg_shift),
        .cfg_count  (cfg_count),
        .hit        (t_hit),
        .sel        (t_sel),
        .offset     (t_offset),
        .shift      (t_shift),
        .count      (t_count)
    );

    tce_index_calc #(
        .ADDR_W   (ADDR_W),
        .SHIFT_W  (SHIFT_W),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) u_index (
        .addr      (cur_addr),
        .offset    (t_offset),
        .shift     (t_shift),
        .count     (t_count),
        .low_mask  (low_mask),
        .page_size (page_size),
        .aligned   (aligned),
        .rel_page  (rel_page),
        .idx       (entry_idx),
        .in_range  (in_range)
    );

    tce_entry_store #(
        .NUM_TABLES (NUM_TABLES),
        .DEPTH      (DEPTH),
        .DATA_W     (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (t_sel),
        .wr_idx  (entry_idx),
        .wr_data (cur_val),
        .rd_sel  (t_sel),
        .rd_idx  (entry_idx),
        .rd_data (rd_data)
    );

    // command-level checks, evaluated in DECODE
    assign list_bad = (count_q > CNT_W'(LIST_MAX)) || (count_q == '0) ||
                      (arg_q[LIST_ALIGN-1:0] != '0);
    assign fill_bad = (count_q > t_count) || (count_q == '0);

    always_comb begin
        pre_err = !t_hit;
        if (op_q == OP_LIST && list_bad) pre_err = 1'b1;
        if (op_q == OP_FILL && fill_bad) pre_err = 1'b1;
    end

    assign total      = (op_q == OP_PUT || op_q == OP_GET) ? CNT_W'(1) : count_q;
    assign last_entry = (done_cnt + CNT_W'(1)) == total;
    assign wr_en      = (state == ST_STEP) && in_range && (op_q != OP_GET);

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (cmd_valid) nstate = ST_DECODE;
            ST_DECODE: begin
                if (pre_err)              nstate = ST_DONE;
                else if (op_q == OP_LIST) nstate = ST_FETCH;
                else                      nstate = ST_STEP;
            end
            ST_FETCH:  if (lst_valid) nstate = ST_STEP;
            ST_STEP: begin
                if (!in_range || op_q == OP_GET || last_entry) nstate = ST_DONE;
                else if (op_q == OP_LIST)                      nstate = ST_FETCH;
                else                                           nstate = ST_STEP;
            end
            ST_DONE:   nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_PUT;
            id_q       <= '0;
            cur_addr   <= '0;
            arg_q      <= '0;
            count_q    <= '0;
            cur_val    <= '0;
            done_cnt   <= '0;
            sts_q      <= STS_PARAM;
            val_q      <= '0;
            inv_valid  <= 1'b0;
            inv_iova   <= '0;
            inv_target <= '0;
            inv_mask   <= '0;
            inv_perm   <= '0;
        end else begin
            inv_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q     <= op_e'(cmd_op);
                        id_q     <= cmd_table;
                        cur_addr <= cmd_addr;
                        arg_q    <= cmd_arg;
                        count_q  <= cmd_count;
                        done_cnt <= '0;
                        sts_q    <= STS_PARAM;
                        val_q    <= '0;
                    end
                end
                ST_DECODE: cur_val <= arg_q;
                ST_FETCH:  if (lst_valid) cur_val <= lst_data;
                ST_STEP: begin
                    if (!in_range) begin
                        sts_q <= STS_PARAM;
                    end else if (op_q == OP_GET) begin
                        sts_q <= STS_OK;
                        val_q <= rd_data;
                    end else begin
                        sts_q      <= STS_OK;
                        inv_valid  <= 1'b1;
                        inv_iova   <= rel_page;
                        inv_target <= cur_val & ~low_mask;
                        inv_mask   <= low_mask;
                        inv_perm   <= decode_perm(cur_val[1:0]);
                        done_cnt   <= done_cnt + CNT_W'(1);
                        cur_addr   <= aligned + page_size;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign cmd_ready    = (state == ST_IDLE);
    assign busy         = (state != ST_IDLE);
    assign lst_ready    = (state == ST_FETCH);
    assign rsp_valid    = (state == ST_DONE);
    assign rsp_status   = sts_q;
    assign rsp_value    = val_q;
    assign rsp_last_idx = (op_q == OP_LIST && done_cnt != '0) ? (done_cnt - CNT_W'(1)) : '0;

endmodule

// File: rtl/tce_cmd_engine_chk.sv
`timescale 1ns/1ps
module tce_cmd_engine_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              busy,
    input logic              lst_ready,
    input logic              rsp_valid,
    input logic [7:0]        rsp_status,
    input logic [ADDR_W-1:0] rsp_value,
    input logic              inv_valid,
    input logic [ADDR_W-1:0] inv_iova,
    input logic [ADDR_W-1:0] inv_target,
    input logic [ADDR_W-1:0] inv_mask
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> busy); // R10

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && !busy); // R10

    AST_NOTIFY_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> busy); // R10

    AST_ERR_VALUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_status != 8'd0) |-> rsp_value == '0); // R5

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status == 8'd0) || (rsp_status == 8'd4)); // R3

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ((inv_mask + 1'b1) & inv_mask) == '0); // R4

    AST_NOTIFY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ((inv_iova & inv_mask) == '0) && ((inv_target & inv_mask) == '0)); // R4

    AST_STREAM_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        lst_ready |-> busy && !rsp_valid); // R9

endmodule

bind tce_cmd_engine tce_cmd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .lst_ready  (lst_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_value  (rsp_value),
    .inv_valid  (inv_valid),
    .inv_iova   (inv_iova),
    .inv_target (inv_target),
    .inv_mask   (inv_mask)
);

// File: tb/tce_cmd_engine_tb.sv
`timescale 1ns/1ps
module tce_cmd_engine_tb;
    localparam int NT = 2;
    localparam int AW = 64;

    typedef struct packed {
        logic [63:0] iova;
        logic [63:0] tgt;
        logic [63:0] msk;
        logic [1:0]  perm;
    } exp_n_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] b_tag [NT];
    logic [63:0] b_off [NT];
    logic [5:0]  b_sh  [NT];
    logic [31:0] b_cnt [NT];

    logic [NT*32-1:0] cfg_tag;
    logic [NT*64-1:0] cfg_offset;
    logic [NT*6-1:0]  cfg_shift;
    logic [NT*32-1:0] cfg_count;

    for (genvar t = 0; t < NT; t++) begin : g_cfg
        assign cfg_tag[t*32 +: 32]    = b_tag[t];
        assign cfg_offset[t*64 +: 64] = b_off[t];
        assign cfg_shift[t*6 +: 6]    = b_sh[t];
        assign cfg_count[t*32 +: 32]  = b_cnt[t];
    end

    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [63:0] cmd_table = '0, cmd_addr = '0, cmd_arg = '0;
    logic [31:0] cmd_count = '0;
    logic        lst_valid = 1'b0;
    logic        lst_ready;
    logic [63:0] lst_data = '0;
    logic        busy, rsp_valid, inv_valid;
    logic [7:0]  rsp_status;
    logic [63:0] rsp_value, inv_iova, inv_target, inv_mask;
    logic [31:0] rsp_last_idx;
    logic [1:0]  inv_perm;

    tce_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_tag(cfg_tag), .cfg_offset(cfg_offset), .cfg_shift(cfg_shift), .cfg_count(cfg_count),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_table(cmd_table),
        .cmd_addr(cmd_addr), .cmd_arg(cmd_arg), .cmd_count(cmd_count),
        .lst_valid(lst_valid), .lst_ready(lst_ready), .lst_data(lst_data),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_value(rsp_value),
        .rsp_last_idx(rsp_last_idx), .inv_valid(inv_valid), .inv_iova(inv_iova),
        .inv_target(inv_target), .inv_mask(inv_mask), .inv_perm(inv_perm)
    );

    int          n_checks = 0;
    int          n_fail = 0;
    logic [63:0] mm [NT][16];
    logic [63:0] lvals [8];
    exp_n_t      nq [$];
    logic        list_open = 1'b0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // every clock: notifications against the model queue, stream window
    always @(negedge clk) begin
        if (rst_n) begin
            if (inv_valid) begin
                if (nq.size() == 0) begin
                    chk("R4", "unexpected notification iova", inv_iova, 64'hx);
                end else begin
                    exp_n_t e;
                    e = nq.pop_front();
                    chk("R4", "notify iova", inv_iova, e.iova);
                    chk("R4", "notify target", inv_target, e.tgt);
                    chk("R4", "notify mask", inv_mask, e.msk);
                    chk("R4", "notify perm", {62'd0, inv_perm}, {62'd0, e.perm});
                end
            end
            if (lst_ready && !list_open)
                chk("R9", "stream taken when none owed", 64'(lst_ready), 64'd0);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < 16; i++) mm[t][i] = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "idle ready after reset", {63'd0, cmd_ready}, 64'd1);
        chk("R10", "busy after reset", {63'd0, busy}, 64'd0);
        chk("R10", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        chk("R4", "inv_valid after reset", {63'd0, inv_valid}, 64'd0);
    endtask

    task automatic run_cmd(input string req, input logic [1:0] op, input logic [63:0] id,
                           input logic [63:0] addr, input logic [63:0] arg, input logic [31:0] cnt);
        int          sel = -1;
        logic [7:0]  e_sts = 8'd4;
        logic [63:0] e_val = '0;
        logic [31:0] e_last = '0;
        int          done = 0;
        int          consume = 0;
        logic        pre_ok;
        logic [63:0] a, d, ix, lm, v;
        if (id[63:32] == 32'd0)
            for (int t = 0; t < NT; t++)
                if (sel < 0 && id[31:0] == b_tag[t]) sel = t;
        if (sel >= 0) begin
            pre_ok = 1'b1;
            if (op == 2'd3 && (cnt > 512 || arg[11:0] != 12'd0 || cnt == 0)) pre_ok = 1'b0;
            if (op == 2'd2 && (cnt > b_cnt[sel] || cnt == 0)) pre_ok = 1'b0;
            if (pre_ok) begin
                lm = (64'd1 << b_sh[sel]) - 64'd1;
                a  = addr & ~lm;
                for (int i = 0; i < ((op < 2'd2) ? 1 : int'(cnt)); i++) begin
                    d  = a - b_off[sel];
                    ix = d >> b_sh[sel];
                    if (op == 2'd3) consume++;
                    if (ix >= 64'(b_cnt[sel])) begin
                        e_sts = 8'd4;
                        break;
                    end
                    if (op == 2'd1) begin
                        e_val = mm[sel][ix[3:0]];
                    end else begin
                        v = (op == 2'd3) ? lvals[i] : arg;
                        mm[sel][ix[3:0]] = v;
                        nq.push_back('{iova: d & ~lm, tgt: v & ~lm, msk: lm, perm: v[1:0]});
                        done++;
                    end
                    e_sts = 8'd0;
                    a = a + (64'd1 << b_sh[sel]);
                end
                if (op == 2'd3 && done > 0) e_last = 32'(done - 1);
            end
        end

        @(negedge clk);
        cmd_op = op; cmd_table = id; cmd_addr = addr; cmd_arg = arg; cmd_count = cnt;
        cmd_valid = 1'b1;
        if (consume > 0) list_open = 1'b1;
        fork
            begin
                @(negedge clk);
                cmd_valid = 1'b0;
            end
            begin
                for (int k = 0; k < consume; k++) begin
                    lst_data  = lvals[k];
                    lst_valid = 1'b1;
                    forever begin
                        @(negedge clk);
                        if (lst_ready) break;
                    end
                    @(negedge clk);
                end
                lst_valid = 1'b0;
                list_open = 1'b0;
            end
        join
        forever begin
            @(negedge clk);
            if (rsp_valid) break;
        end
        chk(req, "status", {56'd0, rsp_status}, {56'd0, e_sts});
        chk(req, "value", rsp_value, e_val);
        if (op == 2'd3) chk(req, "last index", {32'd0, rsp_last_idx}, {32'd0, e_last});
        chk("R10", "busy during response", {63'd0, busy}, 64'd1);
        @(negedge clk);
        chk("R10", "ready after response", {63'd0, cmd_ready}, 64'd1);
        chk(req, "pending notifications", 64'(nq.size()), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        b_tag[0] = 32'h0000_0010; b_off[0] = 64'h0;         b_sh[0] = 6'd12; b_cnt[0] = 32'd16;
        b_tag[1] = 32'h8000_0001; b_off[1] = 64'h4000_0000; b_sh[1] = 6'd16; b_cnt[1] = 32'd8;
        lvals[0] = 64'h1000_0003; lvals[1] = 64'h2000_0001; lvals[2] = 64'h3000_0002;
        lvals[3] = 64'h4000_0000; lvals[4] = 64'h5000_0003; lvals[5] = 64'h6000_0001;
        lvals[6] = 64'h7000_0002; lvals[7] = 64'h8000_0003;

        do_reset();                                                                 // R11
        run_cmd("R11", 2'd1, 64'h10, 64'h3000, 64'h0, 32'd0);
        run_cmd("R4",  2'd0, 64'h10, 64'h3123, 64'hABCD_E003, 32'd0);
        run_cmd("R5",  2'd1, 64'h10, 64'h3FFF, 64'h0, 32'd0);
        run_cmd("R3",  2'd0, 64'h8000_0001, 64'h4002_0005, 64'h12_3456_7801, 32'd0);
        run_cmd("R3",  2'd0, 64'h8000_0001, 64'h1000, 64'h55, 32'd0);
        run_cmd("R3",  2'd0, 64'h8000_0001, 64'h4008_0000, 64'h55, 32'd0);
        run_cmd("R5",  2'd1, 64'h8000_0001, 64'h4008_0000, 64'h0, 32'd0);
        run_cmd("R5",  2'd1, 64'h8000_0001, 64'h4002_FFFF, 64'h0, 32'd0);
        run_cmd("R1",  2'd0, 64'h1_0000_0010, 64'h3000, 64'h99, 32'd0);
        run_cmd("R1",  2'd1, 64'h1_0000_0010, 64'h3000, 64'h0, 32'd0);
        run_cmd("R2",  2'd0, 64'h55, 64'h3000, 64'h99, 32'd0);
        run_cmd("R7",  2'd2, 64'h10, 64'h5abc, 64'h7777_0002, 32'd4);
        run_cmd("R6",  2'd2, 64'h10, 64'h0, 64'h1, 32'd17);
        run_cmd("R6",  2'd2, 64'h10, 64'h0, 64'h1, 32'd0);
        run_cmd("R7",  2'd2, 64'h10, 64'hE000, 64'h6666_0001, 32'd4);
        run_cmd("R7",  2'd1, 64'h10, 64'hF000, 64'h0, 32'd0);
        run_cmd("R6",  2'd1, 64'h10, 64'h0, 64'h0, 32'd0);
        run_cmd("R9",  2'd3, 64'h10, 64'h0, 64'h2000, 32'd3);
        run_cmd("R8",  2'd3, 64'h10, 64'h0, 64'h2008, 32'd2);
        run_cmd("R8",  2'd3, 64'h10, 64'h0, 64'h2000, 32'd513);
        run_cmd("R8",  2'd3, 64'h10, 64'h0, 64'h2000, 32'd0);
        run_cmd("R9",  2'd1, 64'h10, 64'h1000, 64'h0, 32'd0);
        run_cmd("R9",  2'd3, 64'h8000_0001, 64'h4006_1234, 64'h3000, 32'd4);
        run_cmd("R9",  2'd1, 64'h8000_0001, 64'h4007_0000, 64'h0, 32'd0);
        run_cmd("R9",  2'd3, 64'h8000_0001, 64'h4100_0000, 64'h3000, 32'd2);
        do_reset();                                                                 // R11
        run_cmd("R11", 2'd1, 64'h10, 64'h3000, 64'h0, 32'd0);
        run_cmd("R11", 2'd1, 64'h8000_0001, 64'h4002_0000, 64'h0, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule